// File: doc/BRIEF.md
# Hough Line Vote Accumulator

This block builds the voting histogram of a line-finding Hough transform for a binary image that arrives one pixel per handshake, in raster order. Each instance owns one contiguous slice of the angle axis. For every lit pixel it walks through the angles of its slice. For each angle it forms the pixel's signed distance from the origin using 16-bit fixed-point cosine and sine constants, turns that distance into a row address, and adds one vote to the matching counter in on-chip storage.

Several instances built with the same image size and angle resolution, but with different slice numbers, can be fed the same pixel stream. Their histograms are disjoint column blocks of the full result, so they are placed side by side and never added together. A start pulse wipes the counters and begins a new image. Once the final pixel's votes are stored, a done flag rises and the counters can be read one at a time through a small read port.

Top module: `hough_vote_acc`

## Requirements
- R1: Slice `PART_IDX` of `NPART` covers `NT = THETA_RES/NPART` angles with global indices `PART_IDX*NT + k`, for k from 0 to NT-1. Global index g is the angle `-90 + 180*g/THETA_RES` degrees, so +90 is never reached. Local index k is read out on `rd_theta`.
- R2: Each cosine and sine constant is the true value times 32768, rounded to the nearest integer with halves moving away from zero, then clamped to the range -32768 to 32767. For example, cos(0) becomes 32767 and sin(-90) becomes -32768.
- R3: The distance is `(x*C + y*S)/32768`, rounded to the nearest integer with halves away from zero and clamped to signed 16 bits. The distance axis runs from -D to +D, where D is the ceiling of sqrt((ROWS-1)^2+(COLS-1)^2). The row address is distance + D, so `rd_rho` = 0 holds the most negative distance.
- R4: Pixels are taken in raster order. Column x counts fastest and row y slowest, and both start at 0 after a start pulse.
- R5: A pixel with value 1 adds one vote per angle of the slice. A pixel with value 0 changes no counter and is taken in a single cycle.
- R6: A counter that holds `2^CNT_W-1` stays at that value when it receives more votes.
- R7: Votes that land on the same counter in consecutive cycles are all kept. This arises when NT is 1 and neighbouring pixels share a distance.
- R8: A start pulse, including one that arrives partway through an image, drops all work in progress. It zeroes every counter, taking one cycle per counter, and holds `pix_ready` low until the clearing is finished.
- R9: After a lit pixel is taken, `pix_ready` stays low until the last angle of that pixel is being issued. With no gaps in the input, an all-ones image finishes 3 cycles after its last handshake, counted from the end of clearing.
- R10: `done` rises once the final pixel's votes are written. With no gaps in the input, an all-zeros image shows `done` 1 cycle after its last handshake. `done` then stays high, with `pix_ready` low, until the next start pulse.
- R11: While `done` is high, `rd_count` shows the counter at (`rd_theta`, `rd_rho`) one clock after that address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Clear the counters and begin a new image |
| pix_valid | input | 1 | Pixel offered |
| pix_data | input | 1 | Pixel value, 0 or 1 |
| pix_ready | output | 1 | Pixel can be taken this cycle |
| done | output | 1 | All votes of the image are stored |
| rd_theta | input | TW (max(1, clog2(NT))) | Local angle index for readout |
| rd_rho | input | RW (clog2(2D+1)) | Distance row address for readout |
| rd_count | output | CNT_W | Counter value, one cycle after the address |

## Verification
The hardest case to reach is two votes for the same counter issued in back-to-back cycles. A write is still in flight when the next read returns, so a design without forwarding would silently lose one of the votes. The bench uses a one-angle slice at -60 degrees, where two adjacent columns of a row usually share a distance. It then sends horizontal lines and a gap-free all-ones image, so lit pixels arrive on every cycle. The all-ones image also pushes several counters of a 4-bit width past their ceiling, and a second start pulse lands in the middle of a random image.

// File: rtl/hough_pkg.sv
`timescale 1ns/1ps
package hough_pkg;

   typedef enum logic [1:0] {ST_IDLE, ST_CLEAR, ST_RUN, ST_DONE} vote_state_e;

   // smallest r with r*r >= n
   function automatic int ceil_sqrt(input int n);
      int r;
      r = 0;
      while (r * r < n) r++;
      return r;
   endfunction

   // angle in radians of global index g on a grid of res steps from -90 deg
   function automatic real grid_angle(input int g, input int res);
      return (-90.0 + 180.0 * real'(g) / real'(res)) * 3.14159265358979323846 / 180.0;
   endfunction

   // signed Q1.15 with round-half-away and clamping
   function automatic logic signed [15:0] to_q15(input real v);
      real s;
      s = v * 32768.0;
      if (s >= 32767.0)  return 16'sh7fff;
      if (s <= -32768.0) return 16'sh8000;
      if (s >= 0.0) return 16'($rtoi(s + 0.5));
      return 16'($rtoi(s - 0.5));
   endfunction

endpackage

// File: rtl/hough_coef_rom.sv
`timescale 1ns/1ps
module hough_coef_rom #(
   parameter int THETA_RES = 180,
   parameter int NT        = 45,
   parameter int BASE      = 0,
   parameter int TW        = 6
) (
   input  logic [TW-1:0]      t_sel,
   output logic signed [15:0] cos_q,
   output logic signed [15:0] sin_q
);
   import hough_pkg::*;

   logic signed [15:0] cos_tab [NT];
   logic signed [15:0] sin_tab [NT];

   for (genvar g = 0; g < NT; g++) begin : g_ent
      localparam real ANG = grid_angle(BASE + g, THETA_RES);
      assign cos_tab[g] = to_q15($cos(ANG));
      assign sin_tab[g] = to_q15($sin(ANG));
   end

   if (NT == 1) begin : g_single
      logic unused_sel;
      assign unused_sel = ^t_sel;
      assign cos_q = cos_tab[0];
      assign sin_q = sin_tab[0];
   end else begin : g_multi
      assign cos_q = cos_tab[t_sel];
      assign sin_q = sin_tab[t_sel];
   end

endmodule

// File: rtl/hough_rho_unit.sv
`timescale 1ns/1ps
module hough_rho_unit #(
   parameter int XW      = 4,
   parameter int YW      = 4,
   parameter int RW      = 6,
   parameter int RHO_MAX = 22
) (
   input  logic [XW-1:0]      x,
   input  logic [YW-1:0]      y,
   input  logic signed [15:0] cos_q,
   input  logic signed [15:0] sin_q,
   output logic [RW-1:0]      addr
);
   localparam int MW = (XW > YW) ? XW : YW;
   localparam int SW = MW + 19;

   logic signed [SW-1:0] xs, ys, cs, ss, acc, mag, q;
   logic signed [15:0]   rho;

   always_comb begin
      xs  = SW'(x);
      ys  = SW'(y);
      cs  = SW'(cos_q);
      ss  = SW'(sin_q);
      acc = xs * cs + ys * ss;
      mag = (acc < 0) ? -acc : acc;
      q   = (mag + SW'(16384)) >>> 15;
      if (acc < 0) q = -q;
      if (q > SW'(32767))       rho = 16'sh7fff;
      else if (q < -SW'(32768)) rho = 16'sh8000;
      else                      rho = 16'(q);
      addr = RW'(SW'(rho) + SW'(RHO_MAX));
   end

endmodule

// File: rtl/hough_bin_ram.sv
`timescale 1ns/1ps
module hough_bin_ram #(
   parameter int DEPTH = 2025,
   parameter int AW    = 11,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic [AW-1:0]    rd_addr,
   output logic [CNT_W-1:0] rd_q,
   input  logic             we,
   input  logic [AW-1:0]    wr_addr,
   input  logic [CNT_W-1:0] wr_data
);
   logic [CNT_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      rd_q <= mem[rd_addr];
      if (we) mem[wr_addr] <= wr_data;
   end

endmodule

// File: rtl/hough_vote_acc.sv
`timescale 1ns/1ps
module hough_vote_acc #(
   parameter int ROWS      = 16,
   parameter int COLS      = 16,
   parameter int THETA_RES = 180,
   parameter int NPART     = 4,
   parameter int PART_IDX  = 0,
   parameter int CNT_W     = 16,
   localparam int NT       = THETA_RES / NPART,
   localparam int RHO_MAX  = hough_pkg::ceil_sqrt((ROWS-1)*(ROWS-1) + (COLS-1)*(COLS-1)),
   localparam int NBINS    = 2 * RHO_MAX + 1,
   localparam int TW       = (NT > 1) ? $clog2(NT) : 1,
   localparam int RW       = $clog2(NBINS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             pix_valid,
   input  logic             pix_data,
   output logic             pix_ready,
   output logic             done,
   input  logic [TW-1:0]    rd_theta,
   input  logic [RW-1:0]    rd_rho,
   output logic [CNT_W-1:0] rd_count
);
   import hough_pkg::*;

   localparam int DEPTH = NT * NBINS;
   localparam int AW    = $clog2(DEPTH);
   localparam int XW    = (COLS > 1) ? $clog2(COLS) : 1;
   localparam int YW    = (ROWS > 1) ? $clog2(ROWS) : 1;
   localparam int BASE  = PART_IDX * NT;

   if (THETA_RES % NPART != 0) begin : g_bad_split
      $error("THETA_RES must be a multiple of NPART");
   end
   if (PART_IDX >= NPART) begin : g_bad_part
      $error("PART_IDX out of range");
   end
   if (CNT_W < 1 || ROWS < 1 || COLS < 1) begin : g_bad_size
      $error("sizes must be positive");
   end

   vote_state_e      state;
   logic [AW-1:0]    clr_idx;
   logic [XW-1:0]    x_c, x_l;
   logic [YW-1:0]    y_c, y_l;
   logic [TW-1:0]    t_c;
   logic             busy, all_in, last_t, accept, iss_v;
   logic signed [15:0] cos_q, sin_q;
   logic [RW-1:0]    rho_addr;
   logic [AW-1:0]    iss_idx, rd_idx, ram_raddr, ram_waddr;
   logic             s1_v, wb_v, ram_we;
   logic [AW-1:0]    s1_idx, wb_idx;
   logic [CNT_W-1:0] wb_cnt, ram_q, base_cnt, nxt_cnt, ram_wdata;

   assign last_t    = (t_c == TW'(NT - 1));
   assign pix_ready = (state == ST_RUN) && !all_in && (!busy || last_t);
   assign accept    = pix_valid && pix_ready;
   assign iss_v     = busy && (state == ST_RUN);
   assign done      = (state == ST_DONE);

   hough_coef_rom #(.THETA_RES(THETA_RES), .NT(NT), .BASE(BASE), .TW(TW)) u_rom (
      .t_sel(t_c), .cos_q(cos_q), .sin_q(sin_q));

   hough_rho_unit #(.XW(XW), .YW(YW), .RW(RW), .RHO_MAX(RHO_MAX)) u_rho (
      .x(x_l), .y(y_l), .cos_q(cos_q), .sin_q(sin_q), .addr(rho_addr));

   assign iss_idx   = AW'(t_c) * AW'(NBINS) + AW'(rho_addr);
   assign rd_idx    = AW'(rd_theta) * AW'(NBINS) + AW'(rd_rho);
   assign ram_raddr = (state == ST_DONE) ? rd_idx : iss_idx;

   // forward the value written last cycle when it targets the same counter
   assign base_cnt  = (wb_v && wb_idx == s1_idx) ? wb_cnt : ram_q;
   assign nxt_cnt   = (&base_cnt) ? base_cnt : base_cnt + CNT_W'(1);

   assign ram_we    = (state == ST_CLEAR) || s1_v;
   assign ram_waddr = (state == ST_CLEAR) ? clr_idx : s1_idx;
   assign ram_wdata = (state == ST_CLEAR) ? '0 : nxt_cnt;

   hough_bin_ram #(.DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W)) u_ram (
      .clk(clk), .rd_addr(ram_raddr), .rd_q(ram_q),
      .we(ram_we), .wr_addr(ram_waddr), .wr_data(ram_wdata));

   assign rd_count = ram_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         clr_idx <= '0;
         x_c     <= '0;
         y_c     <= '0;
         x_l     <= '0;
         y_l     <= '0;
         t_c     <= '0;
         busy    <= 1'b0;
         all_in  <= 1'b0;
         s1_v    <= 1'b0;
         s1_idx  <= '0;
         wb_v    <= 1'b0;
         wb_idx  <= '0;
         wb_cnt  <= '0;
      end else if (start) begin
         state   <= ST_CLEAR;
         clr_idx <= '0;
         x_c     <= '0;
         y_c     <= '0;
         t_c     <= '0;
         busy    <= 1'b0;
         all_in  <= 1'b0;
         s1_v    <= 1'b0;
         wb_v    <= 1'b0;
      end else begin
         s1_v   <= iss_v;
         s1_idx <= iss_idx;
         wb_v   <= s1_v;
         wb_idx <= s1_idx;
         wb_cnt <= nxt_cnt;
         case (state)
            ST_CLEAR: begin
               clr_idx <= clr_idx + AW'(1);
               if (clr_idx == AW'(DEPTH - 1)) state <= ST_RUN;
            end
            ST_RUN: begin
               if (accept) begin
                  x_l  <= x_c;
                  y_l  <= y_c;
                  busy <= pix_data;
                  t_c  <= '0;
                  if (x_c == XW'(COLS - 1)) begin
                     x_c <= '0;
                     if (y_c == YW'(ROWS - 1)) all_in <= 1'b1;
                     else                      y_c    <= y_c + YW'(1);
                  end else begin
                     x_c <= x_c + XW'(1);
                  end
               end else if (busy) begin
                  if (last_t) busy <= 1'b0;
                  else        t_c  <= t_c + TW'(1);
               end
               if (all_in && !busy && !s1_v) state <= ST_DONE;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/hough_vote_chk.sv
`timescale 1ns/1ps
module hough_vote_chk #(
   parameter int NT    = 45,
   parameter int NBINS = 45,
   parameter int DEPTH = 2025,
   parameter int AW    = 11,
   parameter int RW    = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          pix_valid,
   input logic          pix_data,
   input logic          pix_ready,
   input logic          done,
   input logic          iss_v,
   input logic [RW-1:0] rho_addr,
   input logic          s1_v,
   input logic [AW-1:0] s1_idx
);
   assert_addr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      iss_v |-> (int'(rho_addr) < NBINS));

   assert_idx_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      s1_v |-> (int'(s1_idx) < DEPTH));

   assert_zero_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && pix_ready && !pix_data && !start) |=> !iss_v);

   assert_clear_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!pix_ready && !done));

   assert_sweep_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && pix_ready && pix_data && !start && NT > 1) |=> !pix_ready);

   assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!pix_ready && !s1_v && !iss_v));

endmodule

bind hough_vote_acc hough_vote_chk #(
   .NT(NT), .NBINS(NBINS), .DEPTH(DEPTH), .AW(AW), .RW(RW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .pix_valid(pix_valid),
   .pix_data(pix_data), .pix_ready(pix_ready), .done(done),
   .iss_v(iss_v), .rho_addr(rho_addr), .s1_v(s1_v), .s1_idx(s1_idx)
);

// File: tb/tb_hough_vote_acc.sv
`timescale 1ns/1ps
module tb_hough_vote_acc;
   localparam int R    = 12;
   localparam int C    = 16;
   localparam int RES  = 180;
   localparam int NP   = 180;
   localparam int PI   = 30;
   localparam int CW   = 4;
   localparam int N    = R * C;
   localparam int DMAX = 19;            // ceil(sqrt(11^2+15^2))
   localparam int NB   = 2 * DMAX + 1;  // 39 rows, one angle
   localparam int RWB  = 6;
   localparam int CMAX = (1 << CW) - 1;

   logic clk = 0, rst_n = 0, start = 0, pix_valid = 0, pix_data = 0;
   logic pix_ready, done;
   logic [0:0]     rd_theta = '0;
   logic [RWB-1:0] rd_rho = '0;
   logic [CW-1:0]  rd_count;

   int checks = 0, errors = 0, cyc = 0, e0 = 0;
   bit img [N];
   int expv [NB];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   hough_vote_acc #(.ROWS(R), .COLS(C), .THETA_RES(RES), .NPART(NP),
                    .PART_IDX(PI), .CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .pix_valid(pix_valid),
      .pix_data(pix_data), .pix_ready(pix_ready), .done(done),
      .rd_theta(rd_theta), .rd_rho(rd_rho), .rd_count(rd_count));

   function automatic int q15(input real v);
      real s;
      s = v * 32768.0;
      if (s >= 32767.0) return 32767;
      if (s <= -32768.0) return -32768;
      return (s >= 0.0) ? $rtoi(s + 0.5) : $rtoi(s - 0.5);
   endfunction

   // R2/R3: reference distance for pixel (x,y) at the slice's single angle
   function automatic int rho_of(input int x, input int y);
      real a;
      int cq, sq, acc, m, q;
      a  = (-90.0 + 180.0 * real'(PI) / real'(RES)) * 3.14159265358979323846 / 180.0;
      cq = q15($cos(a));
      sq = q15($sin(a));
      acc = x * cq + y * sq;
      m = (acc < 0) ? -acc : acc;
      q = (m + 16384) / 32768;
      if (acc < 0) q = -q;
      if (q > 32767) q = 32767;
      if (q < -32768) q = -32768;
      return q;
   endfunction

   function automatic void build_ref();
      for (int b = 0; b < NB; b++) expv[b] = 0;
      for (int i = 0; i < N; i++)
         if (img[i]) begin
            int b;
            b = rho_of(i % C, i / C) + DMAX;
            if (expv[b] < CMAX) expv[b]++;
         end
   endfunction

   function automatic void clear_img();
      for (int i = 0; i < N; i++) img[i] = 0;
   endfunction

   task automatic check(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic start_pulse();
      @(negedge clk); pix_valid = 0; start = 1;
      @(negedge clk); start = 0;
      e0 = cyc;
      check("R8 ready low while clearing", int'(pix_ready), 0);
   endtask

   task automatic feed(input int n, input bit gaps);
      int i;
      i = 0;
      while (i < n) begin
         @(negedge clk);
         if (gaps && ($urandom % 4) == 0) pix_valid = 0;
         else begin
            pix_valid = 1;
            pix_data  = img[i];
            if (pix_ready) i++;
         end
      end
      @(negedge clk); pix_valid = 0;
   endtask

   task automatic wait_done(output int elapsed);
      int g;
      g = 0;
      while (!done && g < 5000) begin @(negedge clk); g++; end
      if (!done) check("R10 done never rose", 0, 1);
      elapsed = cyc - e0;
   endtask

   task automatic readout(input string tag);
      for (int b = 0; b < NB; b++) begin
         @(negedge clk); rd_rho = RWB'(b);
         @(negedge clk);
         check($sformatf("%s R11 bin %0d", tag, b), int'(rd_count), expv[b]);
      end
   endtask

   task automatic run_image(input string tag, input bit gaps);
      int el;
      build_ref();
      start_pulse();
      feed(N, gaps);
      wait_done(el);
      readout(tag);
   endtask

   initial begin
      int el, dummy;
      dummy = $urandom(32'd7177);
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R10 done low after reset", int'(done), 0);
      check("R8 ready low after reset", int'(pix_ready), 0);

      // R4/R5: single pixels at both ends of the raster
      clear_img(); img[0] = 1;
      run_image("R4 R5 pixel at origin", 1);
      clear_img(); img[N-1] = 1;
      run_image("R4 R5 pixel at far corner", 1);

      // R7: horizontal line, neighbours share bins back to back
      clear_img(); for (int x = 0; x < C; x++) img[5*C + x] = 1;
      run_image("R7 horizontal line", 0);
      clear_img(); for (int y = 0; y < R; y++) img[y*C + 7] = 1;
      run_image("R3 vertical line", 1);
      clear_img(); for (int y = 0; y < R; y++) img[y*C + y] = 1;
      run_image("R1 R2 diagonal line", 1);

      // R6/R9: all ones without gaps, saturating counters
      for (int i = 0; i < N; i++) img[i] = 1;
      build_ref(); start_pulse(); feed(N, 0); wait_done(el);
      check("R9 all-ones finish cycle", el, NB + N + 3);
      readout("R6 all ones");

      // R5/R10: all zeros without gaps
      clear_img();
      build_ref(); start_pulse(); feed(N, 0); wait_done(el);
      check("R10 all-zeros finish cycle", el, NB + N + 1);
      readout("R5 all zeros");

      // R8: restart in the middle of an image
      for (int i = 0; i < N; i++) img[i] = bit'($urandom % 2);
      start_pulse(); feed(N/2, 1);
      clear_img(); img[3*C + 9] = 1;
      run_image("R8 restart mid image", 1);

      // random images of varied density
      for (int k = 0; k < 3; k++) begin
         for (int i = 0; i < N; i++) img[i] = bit'(($urandom % 8) < (2 + 2*k));
         run_image($sformatf("R1 R2 R3 random %0d", k), 1);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule